// File: doc/BRIEF.md
# Interrupt Status Register with Sticky Events and Live Receiver Status

This block is one 8-bit read-only status register of a packet data modem, placed on a simple microcontroller register bus. It merges two kinds of information. Two bits are sticky event flags, and a read of the register clears them. One flag records that the error-correction decoder has finished a block. The other records that the transmit RF enable control bit has changed level, in either direction. Two further bits are live receiver status, and a read does not touch them. One follows a digital envelope-present indication. The other is an end-of-packet indication, which a small timer drives by counting bit-rate strobes while the received waveform sits near the decision centre.

A companion mask register, supplied as an input, chooses which sticky flags drive the single interrupt output. Firmware reads the register when the interrupt is raised. The read returns the flags as they stand in that cycle and clears them on the following edge. An event that arrives during the read itself is kept.

Top module: `irqs_status_reg`

## Requirements
- R1: A synchronous active-high `rst` clears both sticky flags, the end-of-packet timer and the stored previous transmit-enable level. After reset, with `env_present` low, a read returns 0x00 and `irq` is 0.
- R2: A one-cycle `blk_done` pulse sets bit 7 of the register. The bit holds until a read at the register address. It reads 0 from the cycle after that read onward.
- R3: Every change of `tx_rf_en`, rising or falling, sets bit 3. A level held steady raises no further event. A read clears bit 3 in the same way as bit 7.
- R4: Bit 6 equals `env_present` in the read cycle. It is not latched, and a read does not clear it.
- R5: Bit 5 becomes 1 in the cycle after the 4th `bit_tick` strobe, counted while `near_center` stays high. It returns to 0 in the cycle after `near_center` goes low, and that restarts the count. Strobes that arrive while `near_center` is low are not counted.
- R6: Bits 4, 2, 1 and 0 always read 0.
- R7: If a sticky event arrives in the same cycle as a clearing read, the flag is set after that read.
- R8: `irq` = (bit7 AND `mask_reg[7]`) OR (bit3 AND `mask_reg[3]`). Combinational logic drives it from the registered flags, and the other mask bits have no effect.
- R9: A read is `bus_rd` high with `bus_addr` = 0x05. During that cycle `bus_rdata` carries the register value of that cycle. At any other time `bus_rdata` is 0x00, and a read strobe at any other address clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register bus address |
| bus_rd | input | 1 | Register bus read strobe |
| bus_rdata | output | 8 | Read data, valid in the read cycle |
| blk_done | input | 1 | Decoder block-finished strobe |
| tx_rf_en | input | 1 | Transmit RF enable control level |
| env_present | input | 1 | Envelope-present indication |
| near_center | input | 1 | Received sample near the decision centre |
| bit_tick | input | 1 | Bit-rate strobe |
| mask_reg | input | 8 | Companion interrupt mask register |
| irq | output | 1 | Interrupt request |

## Verification
The collision that matters is a sticky event, either a decoder strobe or a transmit-enable edge, landing in the same cycle as the read that clears its flag. The bench provokes it by setting the flag first. It then raises the event together with the read strobe and checks two reads: the first must still return the flag, and only a second read may return it clear. The end-of-packet timer runs alongside the register reads. A sweep over strobe run lengths from 0 to 6, plus interrupted runs, checks that reads never disturb the timer, and a sweep over all 256 mask values checks the interrupt output.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned BIT_BLK = 7;
    localparam int unsigned BIT_ENV = 6;
    localparam int unsigned BIT_EOP = 5;
    localparam int unsigned BIT_TXC = 3;
    localparam logic [DATA_W-1:0] IRQ_SOURCES = (DATA_W'(1) << BIT_BLK) | (DATA_W'(1) << BIT_TXC);
endpackage

// File: rtl/irqs_sticky_flag.sv
module irqs_sticky_flag #(
    parameter bit EDGE_MODE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic src_in,
    input  logic clr,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } st_t;

    st_t  s_d, s_q;
    logic evt;

    generate
        if (EDGE_MODE) begin : g_edge
            logic prev_d, prev_q;
            always_comb prev_d = src_in;
            always_ff @(posedge clk) begin
                if (rst) prev_q <= 1'b0;
                else     prev_q <= prev_d;
            end
            assign evt = src_in ^ prev_q;
        end else begin : g_level
            assign evt = src_in;
        end
    endgenerate

    always_comb begin
        s_d      = s_q;
        s_d.flag = evt | (s_q.flag & ~clr);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign flag_o = s_q.flag;

    // R7
    evt_sets_chk: assert property (@(posedge clk) disable iff (rst) evt |=> flag_o);
    // R2
    clr_clears_chk: assert property (@(posedge clk) disable iff (rst) (clr && !evt) |=> !flag_o);
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst) (flag_o && !clr) |=> flag_o);
endmodule

// File: rtl/irqs_eop_timer.sv
module irqs_eop_timer #(
    parameter int unsigned STROBES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic near_center,
    input  logic bit_tick,
    output logic eop_o
);
    localparam int unsigned CW = $clog2(STROBES + 1);
    localparam logic [CW-1:0] FULL = CW'(STROBES);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tm_t;

    tm_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (!near_center)
            t_d.cnt = '0;
        else if (bit_tick && (t_q.cnt != FULL))
            t_d.cnt = t_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) t_q <= '0;
        else     t_q <= t_d;
    end

    assign eop_o = (t_q.cnt == FULL);

    // R5
    drop_chk: assert property (@(posedge clk) disable iff (rst) !near_center |=> !eop_o);
    // R5
    keep_chk: assert property (@(posedge clk) disable iff (rst) (eop_o && near_center) |=> eop_o);
    // R5
    no_tick_no_rise_chk: assert property (@(posedge clk) disable iff (rst) (!eop_o && !bit_tick) |=> !eop_o);
endmodule

// File: rtl/irqs_status_reg.sv
module irqs_status_reg
    import irqs_pkg::*;
#(
    parameter int unsigned          ADDR_W      = 8,
    parameter logic [ADDR_W-1:0]    REG_ADDR    = 8'h05,
    parameter int unsigned          EOP_STROBES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              blk_done,
    input  logic              tx_rf_en,
    input  logic              env_present,
    input  logic              near_center,
    input  logic              bit_tick,
    input  logic [DATA_W-1:0] mask_reg,
    output logic              irq
);
    logic              rd_hit;
    logic              blk_flag, txc_flag, eop_bit;
    logic [DATA_W-1:0] stat;

    assign rd_hit = bus_rd && (bus_addr == REG_ADDR);

    irqs_sticky_flag #(.EDGE_MODE(1'b0)) u_blk (
        .clk(clk), .rst(rst), .src_in(blk_done), .clr(rd_hit), .flag_o(blk_flag)
    );

    irqs_sticky_flag #(.EDGE_MODE(1'b1)) u_txc (
        .clk(clk), .rst(rst), .src_in(tx_rf_en), .clr(rd_hit), .flag_o(txc_flag)
    );

    irqs_eop_timer #(.STROBES(EOP_STROBES)) u_eop (
        .clk(clk), .rst(rst), .near_center(near_center), .bit_tick(bit_tick), .eop_o(eop_bit)
    );

    always_comb begin
        stat          = '0;
        stat[BIT_BLK] = blk_flag;
        stat[BIT_ENV] = env_present;
        stat[BIT_EOP] = eop_bit;
        stat[BIT_TXC] = txc_flag;
    end

    assign bus_rdata = rd_hit ? stat : '0;
    assign irq       = |(stat & mask_reg & IRQ_SOURCES);

    // R6
    unused_zero_chk: assert property (@(posedge clk) disable iff (rst) (bus_rdata & 8'h17) == 8'h00);
    // R4
    env_live_chk: assert property (@(posedge clk) disable iff (rst) rd_hit |-> (bus_rdata[BIT_ENV] == env_present));
    // R9
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst) !rd_hit |-> (bus_rdata == 8'h00));
    // R8
    masked_off_chk: assert property (@(posedge clk) disable iff (rst) (!mask_reg[BIT_BLK] && !mask_reg[BIT_TXC]) |-> !irq);
    // R2
    read_drops_irq_chk: assert property (@(posedge clk) disable iff (rst) (rd_hit && !blk_done && $stable(tx_rf_en)) |=> !irq);
endmodule

// File: tb/irqs_status_reg_bench.sv
module irqs_status_reg_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       blk_done = 1'b0, tx_rf_en = 1'b0, env_present = 1'b0;
    logic       near_center = 1'b0, bit_tick = 1'b0;
    logic [7:0] mask_reg = 8'h88;
    logic       irq;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irqs_status_reg u_irqs_status_reg (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .blk_done(blk_done), .tx_rf_en(tx_rf_en), .env_present(env_present),
        .near_center(near_center), .bit_tick(bit_tick), .mask_reg(mask_reg), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] exp, input string req);
        bus_addr = 8'h05;
        bus_rd   = 1'b1;
        #1 chk(req, bus_rdata, exp);
        cyc();
        bus_rd = 1'b0;
    endtask

    task automatic pulse_blk();
        blk_done = 1'b1;
        cyc();
        blk_done = 1'b0;
    endtask

    task automatic strobes(input int n);
        for (int k = 0; k < n; k++) begin
            bit_tick = 1'b1;
            cyc();
            bit_tick = 1'b0;
            cyc();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) cyc();
        rst = 1'b0;
        #1 chk("R1 irq after reset", {7'd0, irq}, 8'h00);
        rd(8'h00, "R1 read after reset");

        // R2 block-ready flag
        pulse_blk();
        #1 chk("R8 irq on blk", {7'd0, irq}, 8'h01);
        cyc(); cyc();
        rd(8'h80, "R2 flag held");
        #1 chk("R2 irq drops after read", {7'd0, irq}, 8'h00);
        rd(8'h00, "R2 cleared by read");

        // R9 wrong address
        pulse_blk();
        bus_addr = 8'h04; bus_rd = 1'b1;
        #1 chk("R9 other address data", bus_rdata, 8'h00);
        cyc();
        bus_rd = 1'b0;
        rd(8'h80, "R9 other address does not clear");
        rd(8'h00, "R9 clear after real read");

        // R3 both edges
        tx_rf_en = 1'b1; cyc();
        rd(8'h08, "R3 rising edge");
        rd(8'h00, "R3 cleared");
        repeat (4) cyc();
        rd(8'h00, "R3 steady level no event");
        tx_rf_en = 1'b0; cyc();
        rd(8'h08, "R3 falling edge");
        rd(8'h00, "R3 cleared after fall");

        // R4 live envelope
        env_present = 1'b1;
        rd(8'h40, "R4 env high");
        rd(8'h40, "R4 env not cleared by read");
        env_present = 1'b0;
        rd(8'h00, "R4 env low");

        // R7 collisions
        pulse_blk();
        blk_done = 1'b1; bus_addr = 8'h05; bus_rd = 1'b1;
        #1 chk("R7 blk snapshot", bus_rdata, 8'h80);
        cyc();
        blk_done = 1'b0; bus_rd = 1'b0;
        rd(8'h80, "R7 blk event kept");
        rd(8'h00, "R7 blk later clear");
        tx_rf_en = 1'b1; cyc();
        tx_rf_en = 1'b0; bus_addr = 8'h05; bus_rd = 1'b1;
        #1 chk("R7 txc snapshot", bus_rdata, 8'h08);
        cyc();
        bus_rd = 1'b0;
        rd(8'h08, "R7 txc event kept");
        rd(8'h00, "R7 txc later clear");

        // R5 run-length sweep
        for (int n = 0; n <= 6; n++) begin
            near_center = 1'b1;
            strobes(n);
            rd((n >= 4) ? 8'h20 : 8'h00, $sformatf("R5 run of %0d strobes", n));
            rd((n >= 4) ? 8'h20 : 8'h00, $sformatf("R5 read keeps eop after %0d", n));
            near_center = 1'b0;
            cyc();
            rd(8'h00, "R5 drop after near low");
        end
        near_center = 1'b1; strobes(2);
        near_center = 1'b0; cyc();
        near_center = 1'b1; strobes(2);
        rd(8'h00, "R5 interrupted run restarts");
        strobes(2);
        rd(8'h20, "R5 full run after restart");
        near_center = 1'b0;
        strobes(5);
        near_center = 1'b1;
        strobes(3);
        rd(8'h00, "R5 strobes while low not counted");
        strobes(1);
        rd(8'h20, "R5 fourth strobe sets");

        // R6 all reads mask unused bits: combined value
        env_present = 1'b1;
        pulse_blk();
        tx_rf_en = 1'b1; cyc();
        rd(8'hE8, "R6 all live, unused zero");
        env_present = 1'b0;

        // R8 mask sweep with both flags, then with block flag only
        pulse_blk();
        tx_rf_en = 1'b0; cyc();
        for (int m = 0; m < 256; m++) begin
            mask_reg = m[7:0];
            #1 chk($sformatf("R8 both flags mask %02h", m), {7'd0, irq}, {7'd0, m[7] | m[3]});
        end
        rd(8'hA8, "R8 flags after sweep");
        pulse_blk();
        for (int m = 0; m < 256; m++) begin
            mask_reg = m[7:0];
            #1 chk($sformatf("R8 blk only mask %02h", m), {7'd0, irq}, {7'd0, m[7]});
        end
        mask_reg = 8'h88;

        // R1 reset mid-activity
        tx_rf_en = 1'b1; cyc();
        tx_rf_en = 1'b0;
        rst = 1'b1; cyc();
        rst = 1'b0;
        #1 chk("R1 irq after mid reset", {7'd0, irq}, 8'h00);
        rd(8'h00, "R1 flags and timer cleared");
        strobes(3);
        rd(8'h00, "R1 timer restarted from zero");
        strobes(1);
        rd(8'h20, "R1 timer counts four after reset");
        near_center = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule